// File: doc/BRIEF.md
# Exception Entry Stack Frame Sequencer

This block builds the stack frame that a processor leaves behind when it takes an interrupt, a trap or a BRK. When it receives a request, it captures the program counter, the status bytes, the current privilege mode and both stack pointers. It then writes the frame one byte per clock cycle through a byte-wide write port. After the last byte it raises a one-cycle completion pulse. That pulse carries the event type for the vector generator, together with the new privilege mode and the updated stack pointers.

The frame layout depends on the event type:

- **Interrupts and traps** always land on the hypervisor stack, whatever mode the processor was in. They carry an extended status byte, which records the width of the return address and the user-mode bit of the interrupted context.
- **Interrupts** add the low status byte with bit 5 cleared. That cleared bit marks an extended frame.
- **Traps** leave the low status byte out.
- **BRK** stays on the stack of the current mode and uses the short frame: program counter, then the low status byte with bit 5 set.

Vector address generation and handler execution belong to other blocks.

Top module: `excp_frame_seq`

## Requirements
- R1: After reset the outputs are `busy`=0, `wr_en`=0, `done`=0, `mode_user`=0, and `hsp_out` and `usp_out` are zero.
- R2: A request is accepted on a clock edge where the block is idle and `req_valid`=1. Writes start in the next cycle and continue one byte per cycle with no gaps. The first byte is written at the captured pointer of the selected stack, and each further byte goes one address lower. `done` rises in the cycle after the last write.
- R3: The program counter is written most significant byte first. The number of bytes comes from `awidth_in`: 00 gives 2 bytes, 01 gives 4, and 10 or 11 give 8. The count is capped at PC_W/8.
- R4: An interrupt (`req_kind`=00) writes three parts, in this order, on the hypervisor stack even when `user_in`=1:
   - the program counter;
   - the extended status byte, laid out as {`user_in`, `ext_misc_in`[4:0], `awidth_in`}, with the user bit at bit 7 and the width code at bits 1:0;
   - `stat_lo_in` with bit 5 forced to 0.
- R5: A trap (`req_kind`=01) writes the program counter and then the extended status byte on the hypervisor stack. It writes no low status byte.
- R6: A BRK (`req_kind`=10) writes the program counter and then `stat_lo_in` with bit 5 forced to 1. It uses the user stack when `user_in`=1 and the hypervisor stack otherwise.
- R7: `done` is high for exactly one cycle, with `done_kind` equal to the accepted `req_kind`. From that cycle on, `mode_user` is 0 after an interrupt or trap and equals the captured `user_in` after a BRK. The low status byte is written unchanged apart from bit 5, so the interrupt-disable bit is never set by the block.
- R8: From the `done` cycle on, the pointer of the stack that was written equals its captured value minus the frame length. The other pointer equals its captured value.
- R9: A request that arrives while `busy`=1, or that carries `req_kind`=11, is ignored. It causes no write and leaves `hsp_out`, `usp_out` and `mode_user` unchanged. Input changes during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request strobe |
| req_kind | input | 2 | 00 interrupt, 01 trap, 10 BRK, 11 reserved |
| pc_in | input | PC_W | Program counter to save |
| stat_lo_in | input | 8 | Low status byte |
| ext_misc_in | input | 5 | Bits 6:2 of the extended status byte |
| user_in | input | 1 | 1 when the processor is in user mode |
| awidth_in | input | 2 | Address width code of the current mode |
| hsp_in | input | SP_W | Hypervisor stack pointer |
| usp_in | input | SP_W | User stack pointer |
| busy | output | 1 | A frame is in progress or completing |
| wr_en | output | 1 | Stack byte write strobe |
| wr_addr | output | SP_W | Stack byte address |
| wr_data | output | 8 | Stack byte data |
| done | output | 1 | One-cycle completion pulse |
| done_kind | output | 2 | Event type, valid with `done` |
| mode_user | output | 1 | Privilege mode after the event (1 = user) |
| hsp_out | output | SP_W | Updated hypervisor stack pointer |
| usp_out | output | SP_W | Updated user stack pointer |

## Verification
The bench checks the following cases and what a faulty design would show in each:

- **User-mode interrupts and traps.** The bench checks that the frame lands on the hypervisor stack. A design that followed the current mode would write to user-stack addresses.
- **BRK.** The bench checks the opposite case: a BRK taken in user mode stays on the user stack and leaves `mode_user` high.
- **Frame length and byte order.** All width codes are covered, including the reserved 11. A wrong byte order, a wrong byte count or a missing or extra status byte shows up as a mismatched address or data word in the scoreboard, or as a `done` that arrives a cycle early or late.
- **Bit 5 of the low status byte.** The bench checks it for both values. A design that passed it through unchanged would show the wrong value.
- **Ignored requests.** The bench sends a request while a frame is in progress, changing the inputs at the same time, and separately sends a reserved event type. A design that accepted either would produce extra writes or moved stack pointers.

// File: rtl/efs_pkg.sv
package efs_pkg;

   typedef enum logic [1:0] {
      EV_IRQ  = 2'b00,
      EV_TRAP = 2'b01,
      EV_BRK  = 2'b10,
      EV_RSVD = 2'b11
   } ev_kind_e;

   // bit 5 of the low status byte tells a short frame (1) from an extended one (0)
   localparam logic [7:0] FRAME_MARK = 8'h20;

   // number of program counter bytes for a width code, capped at the PC width
   function automatic int unsigned pc_bytes(input logic [1:0] wc, input int unsigned cap);
      int unsigned n;
      case (wc)
         2'b00:   n = 2;
         2'b01:   n = 4;
         default: n = 8;
      endcase
      return (n > cap) ? cap : n;
   endfunction

endpackage

// File: rtl/efs_frame_byte.sv
module efs_frame_byte
   import efs_pkg::*;
#(
   parameter int PC_W  = 64,
   parameter int CNT_W = 4
) (
   input  ev_kind_e         kind,
   input  logic [PC_W-1:0]  pc,
   input  logic [7:0]       stat_lo,
   input  logic [4:0]       ext_misc,
   input  logic             user,
   input  logic [1:0]       wcode,
   input  logic [CNT_W-1:0] idx,
   output logic [7:0]       data,
   output logic             last
);

   localparam int PCB    = PC_W / 8;
   localparam int LANE_W = (PCB > 1) ? $clog2(PCB) : 1;

   logic [7:0]        lane [PCB];
   logic [CNT_W-1:0]  nb;
   logic [LANE_W-1:0] lsel;
   logic [7:0]        ext_byte;

   for (genvar g = 0; g < PCB; g++) begin : g_lane
      assign lane[g] = pc[8*g +: 8];
   end

   assign nb       = CNT_W'(pc_bytes(wcode, PCB));
   assign lsel     = LANE_W'(nb - 1'b1 - idx);
   assign ext_byte = {user, ext_misc, wcode};

   always_comb begin
      data = '0;
      last = 1'b0;
      if (idx < nb) begin
         data = lane[lsel];
      end else if (idx == nb) begin
         data = (kind == EV_BRK) ? (stat_lo | FRAME_MARK) : ext_byte;
         last = (kind != EV_IRQ);
      end else begin
         data = stat_lo & ~FRAME_MARK;
         last = 1'b1;
      end
   end

endmodule

// File: rtl/efs_sp_track.sv
module efs_sp_track #(
   parameter int SP_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [SP_W-1:0] hsp_in,
   input  logic [SP_W-1:0] usp_in,
   input  logic            sel_user,
   input  logic            dec,
   output logic [SP_W-1:0] hsp_q,
   output logic [SP_W-1:0] usp_q,
   output logic [SP_W-1:0] cur_sp
);

   localparam int NPTR = 2;

   logic [SP_W-1:0] sp_r   [NPTR];
   logic [SP_W-1:0] sp_new [NPTR];

   assign sp_new[0] = hsp_in;
   assign sp_new[1] = usp_in;

   for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      logic mine;
      assign mine = (g == 1) ? sel_user : !sel_user;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sp_r[g] <= '0;
         else if (load)
            sp_r[g] <= sp_new[g];
         else if (dec && mine)
            sp_r[g] <= sp_r[g] - 1'b1;
      end
   end

   assign hsp_q  = sp_r[0];
   assign usp_q  = sp_r[1];
   assign cur_sp = sel_user ? sp_r[1] : sp_r[0];

endmodule

// File: rtl/excp_frame_seq.sv
module excp_frame_seq
   import efs_pkg::*;
#(
   parameter int PC_W = 64,
   parameter int SP_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [1:0]      req_kind,
   input  logic [PC_W-1:0] pc_in,
   input  logic [7:0]      stat_lo_in,
   input  logic [4:0]      ext_misc_in,
   input  logic            user_in,
   input  logic [1:0]      awidth_in,
   input  logic [SP_W-1:0] hsp_in,
   input  logic [SP_W-1:0] usp_in,
   output logic            busy,
   output logic            wr_en,
   output logic [SP_W-1:0] wr_addr,
   output logic [7:0]      wr_data,
   output logic            done,
   output logic [1:0]      done_kind,
   output logic            mode_user,
   output logic [SP_W-1:0] hsp_out,
   output logic [SP_W-1:0] usp_out
);

   localparam int CNT_W = $clog2(PC_W / 8 + 3);

   if (PC_W != 16 && PC_W != 32 && PC_W != 64) begin : g_bad_pcw
      $error("excp_frame_seq: PC_W must be 16, 32 or 64");
   end
   if (SP_W < 8) begin : g_bad_spw
      $error("excp_frame_seq: SP_W must be at least 8");
   end

   typedef enum logic [1:0] {S_IDLE, S_PUSH, S_DONE} state_e;

   state_e           state_q;
   ev_kind_e         kind_q;
   logic [PC_W-1:0]  pc_q;
   logic [7:0]       lo_q;
   logic [4:0]       misc_q;
   logic             user_q;
   logic [1:0]       wc_q;
   logic [CNT_W-1:0] idx_q;
   logic             mode_q;
   logic             accept;
   logic             last;
   logic             on_user;
   logic [SP_W-1:0]  cur_sp;
   logic [7:0]       fbyte;

   assign accept  = (state_q == S_IDLE) && req_valid && (ev_kind_e'(req_kind) != EV_RSVD);
   assign on_user = (kind_q == EV_BRK) && user_q;

   efs_frame_byte #(.PC_W(PC_W), .CNT_W(CNT_W)) u_fbyte (
      .kind     (kind_q),
      .pc       (pc_q),
      .stat_lo  (lo_q),
      .ext_misc (misc_q),
      .user     (user_q),
      .wcode    (wc_q),
      .idx      (idx_q),
      .data     (fbyte),
      .last     (last)
   );

   efs_sp_track #(.SP_W(SP_W)) u_sp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .hsp_in   (hsp_in),
      .usp_in   (usp_in),
      .sel_user (on_user),
      .dec      (wr_en),
      .hsp_q    (hsp_out),
      .usp_q    (usp_out),
      .cur_sp   (cur_sp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         kind_q  <= EV_IRQ;
         pc_q    <= '0;
         lo_q    <= '0;
         misc_q  <= '0;
         user_q  <= 1'b0;
         wc_q    <= '0;
         idx_q   <= '0;
         mode_q  <= 1'b0;
      end else begin
         case (state_q)
            S_IDLE: begin
               if (accept) begin
                  kind_q  <= ev_kind_e'(req_kind);
                  pc_q    <= pc_in;
                  lo_q    <= stat_lo_in;
                  misc_q  <= ext_misc_in;
                  user_q  <= user_in;
                  wc_q    <= awidth_in;
                  idx_q   <= '0;
                  state_q <= S_PUSH;
               end
            end
            S_PUSH: begin
               idx_q <= idx_q + 1'b1;
               if (last) begin
                  state_q <= S_DONE;
                  mode_q  <= (kind_q == EV_BRK) ? user_q : 1'b0;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != S_IDLE);
   assign wr_en     = (state_q == S_PUSH);
   assign wr_addr   = cur_sp;
   assign wr_data   = fbyte;
   assign done      = (state_q == S_DONE);
   assign done_kind = kind_q;
   assign mode_user = mode_q;

endmodule

// File: rtl/efs_chk.sv
module efs_chk #(
   parameter int SP_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            wr_en,
   input logic [SP_W-1:0] wr_addr,
   input logic [7:0]      wr_data,
   input logic            done,
   input logic [1:0]      done_kind,
   input logic            mode_user
);

   // R2
   wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy);

   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en)) |-> (wr_addr == SP_W'($past(wr_addr) - 1'b1)));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!wr_en && busy));

   // R7
   hyp_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_kind != 2'b10) |-> !mode_user);

   // R4
   irq_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_kind == 2'b00) |-> !$past(wr_data[5]));

   // R6
   brk_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_kind == 2'b10) |-> $past(wr_data[5]));

endmodule

bind excp_frame_seq efs_chk #(.SP_W(SP_W)) u_chk (.*);

// File: tb/excp_frame_seq_tb_top.sv
module excp_frame_seq_tb_top;

   localparam int PC_W = 64;
   localparam int SP_W = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [1:0]      req_kind = '0;
   logic [PC_W-1:0] pc_in = '0;
   logic [7:0]      stat_lo_in = '0;
   logic [4:0]      ext_misc_in = '0;
   logic            user_in = 1'b0;
   logic [1:0]      awidth_in = '0;
   logic [SP_W-1:0] hsp_in = '0;
   logic [SP_W-1:0] usp_in = '0;
   logic            busy, wr_en, done, mode_user;
   logic [SP_W-1:0] wr_addr, hsp_out, usp_out;
   logic [7:0]      wr_data;
   logic [1:0]      done_kind;

   int    checks = 0;
   int    errors = 0;
   bit    finished = 0;
   string cur_tag = "R2";

   typedef struct packed {
      logic [SP_W-1:0] a;
      logic [7:0]      d;
   } wr_t;
   wr_t exp_q[$];

   always #2 clk = ~clk;

   excp_frame_seq #(.PC_W(PC_W), .SP_W(SP_W)) dut_i (.*);

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // monitor: pop the scoreboard for every write the design makes
   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9", "unexpected write addr", 64'(wr_addr), 64'hx);
         end else begin
            wr_t e;
            e = exp_q.pop_front();
            check(wr_addr == e.a, cur_tag, "write addr", 64'(wr_addr), 64'(e.a));
            check(wr_data == e.d, cur_tag, "write data", 64'(wr_data), 64'(e.d));
         end
      end
   end

   // driver: builds the expected frame, issues the request, checks completion
   task automatic run_event(input logic [1:0] k, input logic [63:0] pc, input logic [7:0] lo,
                            input logic [4:0] misc, input logic u, input logic [1:0] wc,
                            input logic [15:0] hsp, input logic [15:0] usp,
                            input bit inject, input string tag);
      int n, len, cnt;
      logic on_u;
      logic [15:0] sp;
      n    = (wc == 2'b00) ? 2 : (wc == 2'b01) ? 4 : 8;
      on_u = (k == 2'b10) && u;
      sp   = on_u ? usp : hsp;
      for (int i = n - 1; i >= 0; i--) begin
         exp_q.push_back({sp, pc[8*i +: 8]});
         sp = sp - 1'b1;
      end
      if (k != 2'b10) begin
         exp_q.push_back({sp, {u, misc, wc}});
         sp = sp - 1'b1;
      end
      if (k == 2'b00) begin
         exp_q.push_back({sp, lo & 8'hDF});
         sp = sp - 1'b1;
      end
      if (k == 2'b10) begin
         exp_q.push_back({sp, lo | 8'h20});
         sp = sp - 1'b1;
      end
      len = exp_q.size();
      cur_tag = tag;
      @(posedge clk); #1;
      req_valid = 1'b1; req_kind = k; pc_in = pc; stat_lo_in = lo; ext_misc_in = misc;
      user_in = u; awidth_in = wc; hsp_in = hsp; usp_in = usp;
      @(posedge clk); #1;
      req_valid = 1'b0;
      if (inject) begin
         fork
            begin
               @(posedge clk); #1;
               req_valid = 1'b1; req_kind = 2'b10; pc_in = ~pc; user_in = ~u;
               hsp_in = 16'h1234; usp_in = 16'h4321; stat_lo_in = ~lo;
               @(posedge clk); #1;
               req_valid = 1'b0;
            end
         join_none
      end
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
      end while (!done && cnt < 40);
      // R2: done one cycle after the last of len writes
      check(cnt == len + 1, "R2", "cycles to done", 64'(cnt), 64'(len + 1));
      check(exp_q.size() == 0, tag, "missing writes", 64'(exp_q.size()), 64'd0);
      // R7
      check(done_kind == k, "R7", "done_kind", 64'(done_kind), 64'(k));
      check(mode_user == ((k == 2'b10) ? u : 1'b0), "R7", "mode_user",
            64'(mode_user), 64'((k == 2'b10) ? u : 1'b0));
      // R8
      check(hsp_out == (on_u ? hsp : sp), "R8", "hsp_out", 64'(hsp_out), 64'(on_u ? hsp : sp));
      check(usp_out == (on_u ? sp : usp), "R8", "usp_out", 64'(usp_out), 64'(on_u ? sp : usp));
      @(negedge clk);
      check(done == 1'b0, "R7", "done width", 64'(done), 64'd0);
      exp_q.delete();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      check(busy == 0 && wr_en == 0 && done == 0, "R1", "busy/wr/done", 64'({busy, wr_en, done}), 64'd0);
      check(mode_user == 0, "R1", "mode_user", 64'(mode_user), 64'd0);
      check(hsp_out == 0 && usp_out == 0, "R1", "stack pointers", 64'({hsp_out, usp_out}), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_event(2'b00, 64'h0000_0000_0000_C3A5, 8'h3F, 5'h15, 1'b1, 2'b00, 16'h01FF, 16'h0FF0, 0, "R4");
      run_event(2'b00, 64'h1122_3344_5566_7788, 8'hFF, 5'h0A, 1'b0, 2'b10, 16'h0180, 16'h0E00, 0, "R3");
      run_event(2'b01, 64'h0000_0000_DEAD_BEEF, 8'hA5, 5'h1F, 1'b1, 2'b01, 16'h0100, 16'h0F00, 0, "R5");
      run_event(2'b01, 64'hCAFE_F00D_0BAD_1DEA, 8'h00, 5'h00, 1'b0, 2'b10, 16'h0003, 16'h0700, 0, "R5");
      run_event(2'b10, 64'h0000_0000_0000_8001, 8'h04, 5'h11, 1'b1, 2'b00, 16'h0200, 16'h0AF0, 0, "R6");
      run_event(2'b10, 64'h0000_0000_1357_9BDF, 8'hDF, 5'h02, 1'b0, 2'b01, 16'h01F0, 16'h0B00, 0, "R6");
      run_event(2'b10, 64'h0F1E_2D3C_4B5A_6978, 8'h24, 5'h03, 1'b1, 2'b11, 16'h0150, 16'h0C80, 0, "R3");
      run_event(2'b00, 64'h0000_0000_89AB_CDEF, 8'h24, 5'h0C, 1'b1, 2'b01, 16'h01C0, 16'h0D00, 1, "R9");

      // R9: reserved kind is ignored
      begin
         logic [SP_W-1:0] h0, u0;
         logic m0;
         h0 = hsp_out; u0 = usp_out; m0 = mode_user;
         @(posedge clk); #1;
         req_valid = 1'b1; req_kind = 2'b11; hsp_in = 16'h0777; usp_in = 16'h0888; user_in = 1'b1;
         @(posedge clk); #1;
         req_valid = 1'b0;
         repeat (4) @(negedge clk);
         check(busy == 0, "R9", "busy after reserved kind", 64'(busy), 64'd0);
         check(hsp_out == h0 && usp_out == u0, "R9", "pointers after reserved kind",
               64'({hsp_out, usp_out}), 64'({h0, u0}));
         check(mode_user == m0, "R9", "mode after reserved kind", 64'(mode_user), 64'(m0));
      end

      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule